// File: doc/BRIEF.md
# Programmable Transfer Acknowledge Generator

This block produces the processor-side handshake for one DRAM controller access. An access opens when the start input is seen at a rising clock edge. The block then waits a programmed number of clock periods, taken from a 3-bit delay field, and asserts the transfer acknowledge. While the acknowledge is low the processor must wait. Once it is high the access has completed. A companion "early" output rises exactly one clock period before the acknowledge. The processor can use it to request its next address, or logic outside the block can use it to build its own acknowledge.

A wait input stretches the count. Every clock period in which it is high during the count adds one period before the acknowledge. The access end input drops both outputs and returns the block to idle. A half-cycle option moves both outputs half a clock later: they are re-registered on the falling edge and a multiplexer selects that copy. All sequencing logic runs on the rising edge.

The control state machine has three states:
- IDLE: no access.
- COUNT: wait states in progress.
- ACK: acknowledge asserted.

Its transitions are:
- LAUNCH_FAST: IDLE to ACK, for a zero delay with no wait.
- LAUNCH_COUNT: IDLE to COUNT.
- STALL: COUNT holds while the wait input is high.
- EXPIRE: COUNT to ACK, when the remaining count is zero.
- ABORT: COUNT to IDLE, on access end.
- RELEASE: ACK to IDLE, on access end.

Top module: `xfer_ack_gen`

## Requirements
- R1: While reset is low, and afterwards with no start, ack_o and early_o are both 0.
- R2: With delay field D (0 to 7 wait states) and no wait, let cycle 0 be the clock period in which start_i is high. Then ack_o is first high in cycle 1+D, and it stays high until access end.
- R3: early_o is high for exactly one clock period per access, namely the period just before ack_o first rises.
- R4: Each clock period in which wait_i is high, from the start period up to the period when the count would finish, delays both outputs by one period. With W such periods, ack_o rises in cycle 1+D+W.
- R5: When access_end_i is high at a rising edge, the block returns to idle. After that edge both outputs are 0. A count in progress is abandoned, and neither output rises again until a new start.
- R6: start_i is ignored while a count is running or the acknowledge is high. It neither restarts nor shortens the count, and it does not disturb an asserted acknowledge.
- R7: With D=0 and no wait, early_o is high during the start period itself, and ack_o is high in the next period.
- R8: With half_i=1, both outputs change half a clock period later, on the falling edge, than with half_i=0. In the first period of ack_o, the output is therefore still 0 before the falling edge and 1 after it.
- R9: A start_i that coincides with access_end_i in the idle state does not open an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access start, sampled at the rising edge |
| wait_i | input | 1 | Extends the wait count by one period per high period |
| access_end_i | input | 1 | Ends the access and clears both outputs |
| delay_i | input | 3 | Number of wait states, 0 to 7, captured at start |
| half_i | input | 1 | 1 selects the falling-edge copies of both outputs |
| ack_o | output | 1 | Transfer acknowledge; 0 means wait, 1 means done |
| early_o | output | 1 | Early acknowledge, one clock ahead of ack_o |

## Verification
Several properties are checked on every rising edge:
- an early pulse is always followed by the acknowledge, and the acknowledge never rises without one;
- the early pulse lasts one period;
- the wait input stalls the count;
- access end clears the acknowledge and wins over a simultaneous start;
- a busy block ignores start;
- the zero-delay path acknowledges on the next edge.

Some behaviour only the bench scenarios can show. These are the exact cycle of the acknowledge for each delay and wait pattern, and the half-period shift of the falling-edge copies, seen by sampling before and after the falling edge. The same holds for the absence of any later output after an aborted count.

// File: rtl/xag_pkg.sv
`timescale 1ns/1ps
package xag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ACK   = 2'd2
    } xag_state_e;

endpackage

// File: rtl/xag_wait_cnt.sv
`timescale 1ns/1ps
// Down-counter holding the wait states still to run.
module xag_wait_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= load_val_i;
        end else if (dec_i && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign zero_o = (remain_q == '0);

endmodule

// File: rtl/xag_ctrl.sv
`timescale 1ns/1ps
// Access sequencer: IDLE -> (COUNT) -> ACK -> IDLE.
module xag_ctrl
    import xag_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wait_i,
    input  logic             end_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic             cnt_zero_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             dec_o,
    output logic             early_o,
    output logic             ack_o,
    output xag_state_e       state_o
);

    xag_state_e st_q;
    xag_state_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i && !end_i) begin
                    if ((delay_i == '0) && !wait_i) begin
                        st_d = ST_ACK;          // LAUNCH_FAST
                    end else begin
                        st_d = ST_COUNT;        // LAUNCH_COUNT
                    end
                end
            end
            ST_COUNT: begin
                if (end_i) begin
                    st_d = ST_IDLE;             // ABORT
                end else if (!wait_i && cnt_zero_i) begin
                    st_d = ST_ACK;              // EXPIRE
                end                             // else STALL / count
            end
            ST_ACK: begin
                if (end_i) begin
                    st_d = ST_IDLE;             // RELEASE
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Output and counter-control logic
    always_comb begin
        load_o     = (st_q == ST_IDLE) && start_i && !end_i;
        // The period that consumes one step is the start period itself
        // unless the wait input holds it.
        load_val_o = (wait_i || (delay_i == '0)) ? delay_i
                                                 : delay_i - 1'b1;
        dec_o      = (st_q == ST_COUNT) && !wait_i && !end_i;
        early_o    = (st_d == ST_ACK) && (st_q != ST_ACK);
        ack_o      = (st_q == ST_ACK);
        state_o    = st_q;
    end

endmodule

// File: rtl/xag_half_edge.sv
`timescale 1ns/1ps
// Optional falling-edge retiming of a group of output bits.
module xag_half_edge #(
    parameter int  NBITS   = 2,
    parameter bit  HALF_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_i,
    input  logic [NBITS-1:0] rise_i,
    output logic [NBITS-1:0] out_o
);

    generate
        if (HALF_EN) begin : g_half
            logic [NBITS-1:0] fall_q;
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fall_q <= '0;
                end else begin
                    fall_q <= rise_i;
                end
            end
            assign out_o = half_i ? fall_q : rise_i;
        end else begin : g_full
            logic unused_half;
            assign unused_half = half_i;
            assign out_o = rise_i;
        end
    endgenerate

endmodule

// File: rtl/xfer_ack_gen.sv
`timescale 1ns/1ps
module xfer_ack_gen
    import xag_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter bit HALF_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wait_i,
    input  logic             access_end_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic             half_i,
    output logic             ack_o,
    output logic             early_o
);

    localparam int OUT_BITS = 2;

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             early_pos;
    logic             ack_pos;
    xag_state_e       st;
    logic [OUT_BITS-1:0] out_sel;

    xag_wait_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    xag_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .wait_i     (wait_i),
        .end_i      (access_end_i),
        .delay_i    (delay_i),
        .cnt_zero_i (cnt_zero),
        .load_o     (cnt_load),
        .load_val_o (cnt_val),
        .dec_o      (cnt_dec),
        .early_o    (early_pos),
        .ack_o      (ack_pos),
        .state_o    (st)
    );

    xag_half_edge #(.NBITS(OUT_BITS), .HALF_EN(HALF_EN)) i_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (half_i),
        .rise_i ({ack_pos, early_pos}),
        .out_o  (out_sel)
    );

    assign ack_o   = out_sel[1];
    assign early_o = out_sel[0];

endmodule

// File: rtl/xag_checker.sv
`timescale 1ns/1ps
module xag_checker
    import xag_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             wait_i,
    input logic             access_end_i,
    input logic [CNT_W-1:0] delay_i,
    input logic             early_pos,
    input logic             ack_pos,
    input xag_state_e       st
);

    AST_EARLY_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        early_pos |=> ack_pos);                                          // R3
    AST_ACK_NEEDS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_pos) |-> $past(early_pos));                            // R3
    AST_EARLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        early_pos |=> !early_pos);                                       // R3
    AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT && wait_i && !access_end_i) |=> (st == ST_COUNT)); // R4
    AST_END_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        access_end_i |=> !ack_pos);                                      // R5
    AST_BUSY_KEEPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK && !access_end_i) |=> ack_pos);                    // R6
    AST_FAST_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_i && delay_i == '0 && !wait_i && !access_end_i)
        |=> ack_pos);                                                    // R7
    AST_END_BEATS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && access_end_i) |=> (st == ST_IDLE));            // R9

endmodule

bind xfer_ack_gen xag_checker #(.CNT_W(CNT_W)) i_xag_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .wait_i       (wait_i),
    .access_end_i (access_end_i),
    .delay_i      (delay_i),
    .early_pos    (early_pos),
    .ack_pos      (ack_pos),
    .st           (st)
);

// File: tb/test_xfer_ack_gen.sv
`timescale 1ns/1ps
module test_xfer_ack_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       wait_i = 1'b0;
    logic       access_end_i = 1'b0;
    logic [2:0] delay_i = '0;
    logic       half_i = 1'b0;
    logic       ack_o;
    logic       early_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    xfer_ack_gen i_xfer_ack_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .wait_i       (wait_i),
        .access_end_i (access_end_i),
        .delay_i      (delay_i),
        .half_i       (half_i),
        .ack_o        (ack_o),
        .early_o      (early_o)
    );

    // Vector table: delay, wait periods, half mode
    localparam int NV = 10;
    localparam int V_D [NV] = '{0, 0, 3, 7, 2, 5, 0, 4, 1, 6};
    localparam int V_W [NV] = '{0, 1, 0, 0, 2, 1, 0, 0, 3, 2};
    localparam int V_H [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock period: drive at +1 ns, sample at +8 ns
    task automatic cyc(input logic s, input logic w, input logic e, input int d);
        @(posedge clk);
        #1;
        start_i = s; wait_i = w; access_end_i = e; delay_i = 3'(d);
        #7;
    endtask

    task automatic close_access();
        cyc(1'b0, 1'b0, 1'b1, 0);
        cyc(1'b0, 1'b0, 1'b0, 0);
        check(!ack_o && !early_o, "R5 outputs low after end", int'({ack_o, early_o}), 0);
    endtask

    task automatic run_vec(input int d, input int w, input int h);
        int   ack_at = -1;
        int   early_at = -1;
        int   early_cnt = 0;
        logic mid_at_ack = 1'b0;
        logic mid = 1'b0;
        bit   held = 1'b1;
        string rq;
        for (int i = 0; i < 14; i++) begin
            @(posedge clk);
            #1;
            start_i = (i == 0); wait_i = (i < w); access_end_i = 1'b0;
            delay_i = 3'(d); half_i = h[0];
            #2 mid = ack_o;
            #5;
            if (early_o) begin
                early_cnt++;
                if (early_at < 0) early_at = i;
            end
            if (ack_o && ack_at < 0) begin
                ack_at = i;
                mid_at_ack = mid;
            end else if (ack_at >= 0 && !ack_o) begin
                held = 1'b0;
            end
        end
        rq = (w > 0) ? "R4 ack cycle" : ((d == 0) ? "R7 ack cycle" : "R2 ack cycle");
        check(ack_at == 1 + d + w, rq, ack_at, 1 + d + w);
        check(early_at == d + w, "R3 early cycle", early_at, d + w);
        check(early_cnt == 1, "R3 early single pulse", early_cnt, 1);
        check(held, "R2 ack held until end", int'(held), 1);
        check(mid_at_ack == (h == 0), "R8 edge of ack rise", int'(mid_at_ack), int'(h == 0));
        close_access();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #23;
        check(!ack_o && !early_o, "R1 during reset", int'({ack_o, early_o}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 0);
        check(!ack_o && !early_o, "R1 idle after reset", int'({ack_o, early_o}), 0);

        // Table walk
        for (int v = 0; v < NV; v++) run_vec(V_D[v], V_W[v], V_H[v]);
        half_i = 1'b0;

        // R7: early visible in the start period itself
        @(posedge clk);
        #1 start_i = 1'b1; delay_i = 3'd0; wait_i = 1'b0; access_end_i = 1'b0;
        #2 check(early_o == 1'b1, "R7 early with start", int'(early_o), 1);
        check(ack_o == 1'b0, "R7 ack not yet", int'(ack_o), 0);
        cyc(1'b0, 1'b0, 1'b0, 0);
        check(ack_o == 1'b1, "R7 ack next period", int'(ack_o), 1);
        close_access();

        // R6: start while acknowledge high
        begin
            bit ok = 1'b1;
            cyc(1'b1, 1'b0, 1'b0, 2);
            for (int i = 1; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 2);
            cyc(1'b1, 1'b0, 1'b0, 0);
            for (int i = 0; i < 4; i++) begin
                if (!ack_o || early_o) ok = 1'b0;
                cyc(1'b0, 1'b0, 1'b0, 0);
            end
            check(ok, "R6 start ignored during ack", int'(ok), 1);
            close_access();
        end

        // R6: start during the count does not restart it
        begin
            int ack_at = -1;
            for (int i = 0; i < 12; i++) begin
                cyc((i == 0) || (i == 2), 1'b0, 1'b0, 5);
                if (ack_o && ack_at < 0) ack_at = i;
            end
            check(ack_at == 6, "R6 restart ignored in count", ack_at, 6);
            close_access();
        end

        // R5: abort during the count
        begin
            int seen = 0;
            for (int i = 0; i < 12; i++) begin
                cyc(i == 0, 1'b0, i == 2, 4);
                if (i >= 2 && (ack_o || early_o)) seen++;
            end
            check(seen == 0, "R5 abort suppresses outputs", seen, 0);
        end

        // R9: start together with end in idle
        begin
            int seen = 0;
            cyc(1'b1, 1'b0, 1'b1, 0);
            if (ack_o || early_o) seen++;
            for (int i = 0; i < 4; i++) begin
                cyc(1'b0, 1'b0, 1'b0, 0);
                if (ack_o || early_o) seen++;
            end
            check(seen == 0, "R9 end wins over start", seen, 0);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule